// File: doc/BRIEF.md
# Accumulating Sawtooth Tone Channel

This block is one sawtooth voice for a sound generator. A 6-bit rate value is added into an 8-bit accumulator once per step. After six additions, the seventh step clears the accumulator, and this forms one ramp cycle. The voice outputs the upper five bits of the accumulator as its sample. An enable bit forces that sample to zero, but the accumulator keeps running while the voice is disabled.

Steps are timed by a programmable divider. The divider counts a CPU-rate tick enable and fires once every twice (period + 1) ticks, where the period is a 12-bit value. Software programs the voice by byte writes to three registers on its own 4 KB address page: a rate register, a period-low register, and a period-high register that also holds the enable bit. Mixing with other voices, scaling for a DAC and register read-back are handled elsewhere.

Top module: `ramp_tone_voice`

## Requirements
- R1: A write takes effect only when wr_addr[15:12] equals 0xB. Bits 11:2 are ignored. wr_addr[1:0] selects 0 = rate, 1 = period low, 2 = period high/enable. Offset 3 and writes to any other page change nothing.
- R2: The rate is wr_data[5:0] of offset 0. It is added to the accumulator at each step. A new rate applies from the next addition and does not alter the accumulator already built.
- R3: The 12-bit period P is formed from offset 2 bits 3:0 (upper four bits) and offset 1 (lower eight bits). Steps occur once every 2*(P+1) tick pulses. The first tick after reset produces a step.
- R4: Each step advances a step count. Steps 1 to 6 of a cycle add the rate. Step 7 clears both the accumulator and the count to zero.
- R5: The accumulator is 8 bits wide and wraps modulo 256. It never saturates.
- R6: sample equals accumulator bits 7:3 when offset 2 bit 7 is set, and 0 otherwise. The accumulator keeps stepping while the voice is disabled.
- R7: A synchronous active-low reset clears all register fields, the divider, the step count and the accumulator, so sample reads 0.
- R8: Clock cycles without a tick change neither the divider nor the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | CPU-rate tick enable that clocks the divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| sample | output | 5 | Sawtooth sample, accumulator bits 7:3 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, page 0xB, a 6-bit rate, a 12-bit period, an 8-bit accumulator and a 7-step cycle. Because the accumulator is only 8 bits wide, a rate of 63 reaches the modular wrap within one ramp cycle. Because the period is 12 bits, a period of 0x100 exercises the upper period field with a 514-tick interval, and that interval can be counted edge by edge. The small periods give 2-tick and 6-tick intervals, so the bench can check every step of a full seven-step cycle, including the clear, within a few dozen cycles.

// File: rtl/ramp_pkg.sv
// Package: shared register selector encoding for the sawtooth voice.
// Assumes register offsets are taken from the two lowest address bits.
package ramp_pkg;
    typedef enum logic [1:0] {
        SEL_RATE  = 2'd0,
        SEL_PLOW  = 2'd1,
        SEL_PHIGH = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ramp_regs.sv
// Module: ramp_regs
// Decodes byte writes on the voice's address page and holds the rate,
// the period and the enable bit. Assumes 9 <= PER_W <= 16 so the upper
// period field fits in the low bits of the high-period byte.
module ramp_regs
    import ramp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_ID = 11,
    parameter int RATE_W  = 6,
    parameter int PER_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [RATE_W-1:0] rate_q,
    output logic [PER_W-1:0]  period_q,
    output logic              en_q
);
    localparam int HI_W = PER_W - 8;

    reg_sel_e sel;
    logic     page_hit;

    // Decode the page and the register offset.
    always_comb begin
        page_hit = (wr_addr[ADDR_W-1 -: 4] == 4'(PAGE_ID));
        sel      = reg_sel_e'(wr_addr[1:0]);
    end

    // Capture write data into the selected register field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            period_q <= '0;
            en_q     <= 1'b0;
        end else if (wr_en && page_hit) begin
            case (sel)
                SEL_RATE:  rate_q <= wr_data[RATE_W-1:0];
                SEL_PLOW:  period_q[7:0] <= wr_data;
                SEL_PHIGH: begin
                    period_q[PER_W-1:8] <= wr_data[HI_W-1:0];
                    en_q                <= wr_data[7];
                end
                default: ;
            endcase
        end
    end

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (rate_q == '0 && period_q == '0 && !en_q));

    p_foreign_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr[ADDR_W-1 -: 4] != 4'(PAGE_ID)))
        |=> ($stable(rate_q) && $stable(period_q) && $stable(en_q)));

    p_offset3_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1:0] == 2'd3)
        |=> ($stable(rate_q) && $stable(period_q) && $stable(en_q)));
endmodule

// File: rtl/ramp_divider.sv
// Module: ramp_divider
// Down-counter on the tick enable. It fires a one-cycle step pulse every
// 2*(period+1) ticks. The counter resets to zero, so the first tick steps,
// and a period change is picked up at the next reload.
module ramp_divider #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    localparam int DIV_W = PER_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;

    // Reload value 2P+1 yields an interval of 2(P+1) ticks.
    always_comb begin
        reload = {period, 1'b1};
        step   = tick && (cnt_q == '0);
    end

    // Count down on each tick and reload when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - DIV_W'(1);
    end

    p_step_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tick);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));
endmodule

// File: rtl/ramp_accum.sv
// Module: ramp_accum
// Adds the rate into a modular accumulator on each step and counts steps.
// On the last step of a cycle it clears both the accumulator and the count.
module ramp_accum #(
    parameter int RATE_W = 6,
    parameter int ACC_W  = 8,
    parameter int STEPS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [RATE_W-1:0] rate,
    output logic [ACC_W-1:0]  acc_q
);
    localparam int STEP_W = $clog2(STEPS);

    logic [STEP_W-1:0] idx_q;
    logic              last;

    // Flag the step that ends a ramp cycle.
    always_comb last = (idx_q == STEP_W'(STEPS - 1));

    // Add the rate with modular wrap, or clear at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (step) begin
            if (last) begin
                acc_q <= '0;
                idx_q <= '0;
            end else begin
                acc_q <= acc_q + ACC_W'(rate);
                idx_q <= idx_q + STEP_W'(1);
            end
        end
    end

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= STEP_W'(STEPS - 1));

    p_cycle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (acc_q == '0 && idx_q == '0));

    p_hold_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(acc_q) && $stable(idx_q)));
endmodule

// File: rtl/ramp_tone_voice.sv
// Module: ramp_tone_voice
// Top of the sawtooth voice. It ties together the register decode, the
// period divider and the accumulator, and gates the sample with the enable.
// Assumes the tick input is a one-cycle enable at the CPU rate.
module ramp_tone_voice #(
    parameter int ADDR_W  = 16,
    parameter int PAGE_ID = 11,
    parameter int RATE_W  = 6,
    parameter int PER_W   = 12,
    parameter int ACC_W   = 8,
    parameter int SHIFT   = 3,
    parameter int STEPS   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic [ACC_W-SHIFT-1:0] sample
);
    localparam int OUT_W = ACC_W - SHIFT;

    logic [RATE_W-1:0] rate;
    logic [PER_W-1:0]  period;
    logic              enable;
    logic              step;
    logic [ACC_W-1:0]  acc;

    ramp_regs #(.ADDR_W(ADDR_W), .PAGE_ID(PAGE_ID), .RATE_W(RATE_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate_q(rate), .period_q(period), .en_q(enable)
    );

    ramp_divider #(.PER_W(PER_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period), .step(step)
    );

    ramp_accum #(.RATE_W(RATE_W), .ACC_W(ACC_W), .STEPS(STEPS)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(step), .rate(rate), .acc_q(acc)
    );

    // Output the upper accumulator bits, or silence when disabled.
    always_comb sample = enable ? acc[ACC_W-1:SHIFT] : OUT_W'(0);

    p_silent_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $stable(enable)) |-> (sample == '0));

    p_step_moves_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && enable && $past(enable)) |=> $stable(sample));
endmodule

// File: tb/sim_ramp_tone_voice.sv
module sim_ramp_tone_voice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  sample;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ramp_tone_voice u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sample(sample)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 sample in reset", sample, 0);
        rst_n = 1'b1;
        wr(16'hB002, 8'h80);
        check("R7 zero accumulator after reset", sample, 0);
    endtask

    task automatic t_ramp();
        int exp_seq[8] = '{2, 4, 6, 8, 10, 12, 0, 2};
        do_reset();
        wr(16'hB000, 8'd16); wr(16'hB001, 8'd0); wr(16'hB002, 8'h80);
        ticks(1);
        check("R3 first tick steps", sample, exp_seq[0]);
        for (int i = 1; i < 8; i++) begin
            ticks(2);
            check("R4 ramp step", sample, exp_seq[i]);
        end
    endtask

    task automatic t_period();
        do_reset();
        wr(16'hB000, 8'd8); wr(16'hB001, 8'd2); wr(16'hB002, 8'h80);
        ticks(1);
        check("R3 first step P=2", sample, 1);
        ticks(5);
        check("R3 no step before 6 ticks", sample, 1);
        ticks(1);
        check("R3 step at 6 ticks", sample, 2);
        do_reset();
        wr(16'hB000, 8'd8); wr(16'hB001, 8'd0); wr(16'hB002, 8'h81);
        ticks(1);
        check("R3 first step P=0x100", sample, 1);
        ticks(513);
        check("R3 no step before 514 ticks", sample, 1);
        ticks(1);
        check("R3 step at 514 ticks", sample, 2);
    endtask

    task automatic t_wrap();
        int exp_seq[7] = '{7, 15, 23, 31, 7, 15, 0};
        do_reset();
        wr(16'hB000, 8'hFF); wr(16'hB002, 8'h80);
        ticks(1);
        check("R5 wrap step", sample, exp_seq[0]);
        for (int i = 1; i < 7; i++) begin
            ticks(2);
            check("R5 wrap step", sample, exp_seq[i]);
        end
    endtask

    task automatic t_enable();
        do_reset();
        wr(16'hB000, 8'd16); wr(16'hB002, 8'h00);
        ticks(5);
        check("R6 silent when disabled", sample, 0);
        wr(16'hB002, 8'h80);
        check("R6 accumulator ran while disabled", sample, 6);
        wr(16'hB002, 8'h00);
        check("R6 disable silences", sample, 0);
    endtask

    task automatic t_decode();
        do_reset();
        wr(16'hB000, 8'd8); wr(16'hB002, 8'h80);
        ticks(1);
        wr(16'hA000, 8'h3F); wr(16'h9002, 8'h00); wr(16'hB003, 8'hFF);
        check("R1 foreign writes keep enable", sample, 1);
        ticks(2);
        check("R1 foreign writes keep rate and period", sample, 2);
        wr(16'hB7F0, 8'h10);
        check("R2 rate change leaves accumulator", sample, 2);
        ticks(2);
        check("R2 new rate from next addition", sample, 4);
    endtask

    task automatic t_idle();
        do_reset();
        wr(16'hB000, 8'd24); wr(16'hB002, 8'h80);
        repeat (10) @(negedge clk);
        check("R8 no tick no step", sample, 0);
        ticks(1);
        check("R8 tick steps", sample, 3);
        repeat (10) @(negedge clk);
        check("R8 hold without tick", sample, 3);
        ticks(2);
        check("R8 interval counted in ticks only", sample, 6);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_ramp();
        t_period();
        t_wrap();
        t_enable();
        t_decode();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule